// File: doc/BRIEF.md
# Bus-Mapped Dual Interval Timer

This block adds one or two independent 32-bit interval timers to a simple word-wide register bus. Each channel has a control register, a load register and a live counter. Software writes a start value into the load register, then writes the control register with the enable bit set. From then on the channel counts once per system clock, either down toward zero or up toward all-ones. When it reaches its end value, the channel raises its interrupt flag. With auto-reload set, it starts over from the load value on the same clock edge. Without auto-reload, it stops and holds the end value.

All channels feed one registered level interrupt line. The line is high while any channel has both its flag and its interrupt enable set. A flag is cleared by writing a one to its bit in the control register. The number of channels is set by the parameter `SINGLE`: two channels by default, one channel when `SINGLE` is set. The address window always spans two channels of four words each.

The register bus has no handshake and never back-pressures. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`.

Top module: `mm_timer_pair`

## Requirements
- R1: After reset every readable word returns zero, both counters are stopped and `irq` is low.
- R2: With control bit 1 (count down) set, enabling the channel loads the counter with the load value L. The counter then decrements once per clock. Expiry happens on the edge where the counter holds 1 or 0, so the flag (control bit 8) is set max(1, L) edges after the start.
- R3: With control bit 1 clear, the counter increments from L. Expiry happens on the edge where it holds all-ones minus one or all-ones, so the flag is set max(1, 2^32-1-L) edges after the start.
- R4: With control bit 4 (auto-reload) clear, the channel stops after expiry. The counter then holds 0 when counting down, or all-ones when counting up.
- R5: With control bit 4 set, the counter is reloaded with L on the expiry edge and keeps counting. The count is therefore periodic, with the period given in R2 or R3.
- R6: A control write with bit 8 set clears the flag. A write never sets the flag. If an expiry falls on the same edge as the clearing write, the flag is still set.
- R7: `irq` is registered. It goes high one clock after any channel has both its flag and its interrupt enable (control bit 6) set. It is low otherwise.
- R8: A control write with bit 7 set (re)starts the channel from the load value. A control write with bit 7 clear halts the channel, and the counter keeps its value.
- R9: A load write does not disturb a running count. The new value is used at the next start or auto-reload.
- R10: The control register stores its low 11 bits and reads them back with bit 8 showing the flag; the upper bits read zero. Bits 0, 2, 3, 5, 9 and 10 are stored but have no effect on counting.
- R11: Word address bit 2 selects the channel and bits 1:0 select the word: 0 control, 1 load, 2 counter. Word 3 reads zero and ignores writes. With `SINGLE` set, the channel-1 words read zero, ignore writes and never raise `irq`.
- R12: The two channels count, expire and reload independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counters step on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address: bit 2 is the channel, bits 1:0 the word |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Shared registered level interrupt |

## Verification
The counting function is driven with a sweep of small down-count load values, including zero, and with up-count values close to all-ones. These separate the "one edge minimum" rule from the plain step count and show where each direction stops. The same sweeps are repeated with auto-reload set, so the period and the reload value are checked over several periods rather than only at the first expiry. Targeted sequences then place a flag-clearing write exactly on an expiry edge, change the load value in the middle of a count, halt and restart a count, and run both channels at once. These tell write priority, load isolation and channel independence apart from ordinary counting.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;
  // Control register field positions (software-visible encoding).
  localparam int CTL_W     = 11;
  localparam int CB_MODE   = 0;
  localparam int CB_DOWN   = 1;
  localparam int CB_GEN    = 2;
  localparam int CB_CAPT   = 3;
  localparam int CB_RELOAD = 4;
  localparam int CB_LDBIT  = 5;
  localparam int CB_IEN    = 6;
  localparam int CB_RUN    = 7;
  localparam int CB_FLAG   = 8;
  localparam int CB_PWM    = 9;
  localparam int CB_ALL    = 10;

  // Per-channel word map.
  localparam int SLOT_BITS = 2;
  localparam int MAX_CH    = 2;
  localparam int ADDR_W    = SLOT_BITS + $clog2(MAX_CH);

  typedef enum logic [SLOT_BITS-1:0] {
    SLOT_CTL   = 2'd0,
    SLOT_LOAD  = 2'd1,
    SLOT_CNT   = 2'd2,
    SLOT_SPARE = 2'd3
  } slot_e;
endpackage

// File: rtl/mm_timer_chan.sv
module mm_timer_chan
  import mm_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic             load_we,
  input  logic [DW-1:0]    wdata,
  output logic [CTL_W-1:0] ctl_rd,
  output logic [DW-1:0]    load_rd,
  output logic [DW-1:0]    cnt_rd,
  output logic             run_o,
  output logic             flag_o,
  output logic             ien_o,
  output logic             down_o
);
  logic [CTL_W-1:0] ctl_r;
  logic [DW-1:0]    load_r, cnt_r;
  logic             run_r, flag_r;
  logic             down, at_term, expire, clr;

  assign down    = ctl_r[CB_DOWN];
  // Terminal is reached on this edge when the count is one step away or already there.
  assign at_term = down ? (cnt_r[DW-1:1] == '0) : (&cnt_r[DW-1:1]);
  assign expire  = run_r & at_term;
  assign clr     = ctl_we & wdata[CB_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_r  <= '0;
      load_r <= '0;
      cnt_r  <= '0;
      run_r  <= 1'b0;
      flag_r <= 1'b0;
    end else begin
      flag_r <= (flag_r & ~clr) | expire;
      if (load_we) load_r <= wdata;
      if (ctl_we) begin
        ctl_r <= wdata[CTL_W-1:0] & ~(CTL_W'(1) << CB_FLAG);
        if (wdata[CB_RUN]) begin
          run_r <= 1'b1;
          cnt_r <= load_r;
        end else begin
          run_r <= 1'b0;
        end
      end else if (expire) begin
        if (ctl_r[CB_RELOAD]) begin
          cnt_r <= load_r;
        end else begin
          cnt_r <= down ? '0 : '1;
          run_r <= 1'b0;
        end
      end else if (run_r) begin
        cnt_r <= down ? cnt_r - DW'(1) : cnt_r + DW'(1);
      end
    end
  end

  always_comb begin
    ctl_rd          = ctl_r;
    ctl_rd[CB_FLAG] = flag_r;
  end

  assign load_rd = load_r;
  assign cnt_rd  = cnt_r;
  assign run_o   = run_r;
  assign flag_o  = flag_r;
  assign ien_o   = ctl_r[CB_IEN];
  assign down_o  = down;
endmodule

// File: rtl/mm_timer_decode.sv
module mm_timer_decode
  import mm_timer_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int NUM_CH = 2
) (
  input  logic [AW-1:0]           addr,
  input  logic                    wr,
  output logic                    hit,
  output logic [AW-SLOT_BITS-1:0] ch_sel,
  output slot_e                   slot,
  output logic [NUM_CH-1:0]       ctl_we,
  output logic [NUM_CH-1:0]       load_we
);
  localparam int CH_W = AW - SLOT_BITS;

  assign ch_sel = addr[AW-1:SLOT_BITS];
  assign slot   = slot_e'(addr[SLOT_BITS-1:0]);
  assign hit    = (int'(ch_sel) < NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_we
    assign ctl_we[c]  = wr && hit && (ch_sel == CH_W'(c)) && (slot == SLOT_CTL);
    assign load_we[c] = wr && hit && (ch_sel == CH_W'(c)) && (slot == SLOT_LOAD);
  end
endmodule

// File: rtl/mm_timer_irq.sv
module mm_timer_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |req;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mm_timer_pair.sv
module mm_timer_pair
  import mm_timer_pkg::*;
#(
  parameter int DW     = 32,
  parameter bit SINGLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  localparam int NUM_CH = SINGLE ? 1 : 2;
  localparam int CH_W   = ADDR_W - SLOT_BITS;

  logic                          hit;
  logic [CH_W-1:0]               ch_sel;
  slot_e                         slot;
  logic [NUM_CH-1:0]             ctl_we, load_we;
  logic [NUM_CH-1:0][CTL_W-1:0]  ctl_vec;
  logic [NUM_CH-1:0][DW-1:0]     load_vec, cnt_vec;
  logic [NUM_CH-1:0]             run_vec, flag_vec, ien_vec, down_vec, req_vec;

  mm_timer_decode #(.AW(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .hit     (hit),
    .ch_sel  (ch_sel),
    .slot    (slot),
    .ctl_we  (ctl_we),
    .load_we (load_we)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mm_timer_chan #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .ctl_we  (ctl_we[c]),
      .load_we (load_we[c]),
      .wdata   (bus_wdata),
      .ctl_rd  (ctl_vec[c]),
      .load_rd (load_vec[c]),
      .cnt_rd  (cnt_vec[c]),
      .run_o   (run_vec[c]),
      .flag_o  (flag_vec[c]),
      .ien_o   (ien_vec[c]),
      .down_o  (down_vec[c])
    );
  end

  assign req_vec = flag_vec & ien_vec;

  mm_timer_irq #(.N(NUM_CH)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .req   (req_vec),
    .irq_o (irq)
  );

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit && (ch_sel == CH_W'(c))) begin
        case (slot)
          SLOT_CTL:  bus_rdata = DW'(ctl_vec[c]);
          SLOT_LOAD: bus_rdata = load_vec[c];
          SLOT_CNT:  bus_rdata = cnt_vec[c];
          default:   bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/mm_timer_pair_chk.sv
module mm_timer_pair_chk
  import mm_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      irq,
  input logic [NUM_CH-1:0]         run_vec,
  input logic [NUM_CH-1:0]         flag_vec,
  input logic [NUM_CH-1:0]         ien_vec,
  input logic [NUM_CH-1:0]         down_vec,
  input logic [NUM_CH-1:0]         ctl_we,
  input logic [NUM_CH-1:0][DW-1:0] cnt_vec,
  input logic [DW-1:0]             bus_wdata
);
  p_irq_lag_r7: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(flag_vec & ien_vec)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    p_down_step_r2: assert property (@(posedge clk) disable iff (rst)
      (run_vec[c] && down_vec[c] && !ctl_we[c] && cnt_vec[c] > DW'(1))
      |=> cnt_vec[c] == $past(cnt_vec[c]) - DW'(1));

    p_up_step_r3: assert property (@(posedge clk) disable iff (rst)
      (run_vec[c] && !down_vec[c] && !ctl_we[c] && cnt_vec[c] < ({DW{1'b1}} - DW'(1)))
      |=> cnt_vec[c] == $past(cnt_vec[c]) + DW'(1));

    p_halt_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!run_vec[c] && !ctl_we[c]) |=> $stable(cnt_vec[c]));

    p_start_run_r8: assert property (@(posedge clk) disable iff (rst)
      (ctl_we[c] && bus_wdata[CB_RUN]) |=> run_vec[c]);

    p_flag_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (!run_vec[c] && ctl_we[c] && bus_wdata[CB_FLAG]) |=> !flag_vec[c]);

    p_flag_keep_r6: assert property (@(posedge clk) disable iff (rst)
      (flag_vec[c] && !ctl_we[c]) |=> flag_vec[c]);
  end
endmodule

bind mm_timer_pair mm_timer_pair_chk #(.NUM_CH(NUM_CH), .DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .irq       (irq),
  .run_vec   (run_vec),
  .flag_vec  (flag_vec),
  .ien_vec   (ien_vec),
  .down_vec  (down_vec),
  .ctl_we    (ctl_we),
  .cnt_vec   (cnt_vec),
  .bus_wdata (bus_wdata)
);

// File: tb/mm_timer_pair_tb_top.sv
module mm_timer_pair_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [31:0] B_DOWN  = 32'h0000_0002;
  localparam logic [31:0] B_RLD   = 32'h0000_0010;
  localparam logic [31:0] B_IEN   = 32'h0000_0040;
  localparam logic [31:0] B_EN    = 32'h0000_0080;
  localparam logic [31:0] B_FLAG  = 32'h0000_0100;
  localparam logic [31:0] B_INERT = 32'h0000_062D;
  localparam logic [31:0] ALL1    = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata1;
  logic        irq, irq1;
  int          n_chk = 0;
  int          n_err = 0;

  always #2 clk = ~clk;

  mm_timer_pair #(.DW(32), .SINGLE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  mm_timer_pair #(.DW(32), .SINGLE(1'b1)) dut1_i (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata1), .irq(irq1));

  function automatic logic [2:0] adr(input int ch, input int slot);
    return {ch[0], slot[1:0]};
  endfunction

  function automatic int period(input logic down, input logic [31:0] l);
    logic [31:0] span;
    span = down ? l : (ALL1 - l);
    return (span == 32'd0) ? 1 : int'(span);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr    = 1'b1;
    @(negedge clk);
    wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #0.4;
    d = rdata;
  endtask

  task automatic rd1(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #0.4;
    d = rdata1;
  endtask

  // One-shot run: count and flag sampled after every edge, then the stop value held.
  task automatic run_once(input string tag, input int ch, input logic down,
                          input logic [31:0] l, input logic [31:0] extra);
    logic [31:0] v, expc;
    int p;
    p = period(down, l);
    wrw(adr(ch, 1), l);
    wrw(adr(ch, 0), B_EN | (down ? B_DOWN : 32'd0) | extra);
    rd(adr(ch, 2), v);
    chk({tag, " start value"}, v, l);
    for (int k = 1; k <= p + 2; k++) begin
      @(negedge clk);
      if (k >= p) expc = down ? 32'd0 : ALL1;
      else        expc = down ? l - 32'(k) : l + 32'(k);
      rd(adr(ch, 2), v);
      chk((k > p) ? "R4 stopped count" : {tag, " count"}, v, expc);
      rd(adr(ch, 0), v);
      chk({tag, " flag timing"}, {31'd0, v[8]}, {31'd0, (k >= p)});
    end
    wrw(adr(ch, 0), B_FLAG);
    rd(adr(ch, 0), v);
    chk("R6 flag cleared", {31'd0, v[8]}, 32'd0);
  endtask

  // Auto-reload run over three periods.
  task automatic run_reload(input int ch, input logic down, input logic [31:0] l);
    logic [31:0] v, expc;
    int p;
    p = period(down, l);
    wrw(adr(ch, 1), l);
    wrw(adr(ch, 0), B_EN | B_RLD | (down ? B_DOWN : 32'd0));
    for (int k = 1; k <= 3 * p + 1; k++) begin
      @(negedge clk);
      expc = down ? l - 32'(k % p) : l + 32'(k % p);
      rd(adr(ch, 2), v);
      chk("R5 periodic count", v, expc);
      if (k == p || k == p - 1) begin
        rd(adr(ch, 0), v);
        chk("R5 flag at first expiry", {31'd0, v[8]}, {31'd0, (k == p)});
      end
    end
    wrw(adr(ch, 0), 32'd0);
    wrw(adr(ch, 0), B_FLAG);
  endtask

  initial begin
    #(4 * 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, v1;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, 32'd0);
      rd1(3'(a), v1);
      chk("R1 reset read single", v1, 32'd0);
    end
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    @(negedge clk);
    rd(adr(0, 2), v);
    chk("R1 counter stopped", v, 32'd0);

    // R2 / R4: down-count sweep, one-shot
    for (int l = 0; l <= 6; l++) run_once("R2", 0, 1'b1, 32'(l), 32'd0);
    // R3 / R4: up-count sweep near all-ones
    for (int d = 0; d <= 5; d++) run_once("R3", 0, 1'b0, ALL1 - 32'(d), 32'd0);
    // R10: inert control bits change nothing (channel 1)
    run_once("R10", 1, 1'b1, 32'd5, B_INERT);
    chk("R7 no irq without enable", {31'd0, irq}, 32'd0);

    // R5: auto-reload
    for (int l = 0; l <= 4; l++) run_reload(0, 1'b1, 32'(l));
    run_reload(1, 1'b0, ALL1 - 32'd2);

    // R6: write never sets flag; clear colliding with expiry keeps it
    wrw(adr(0, 0), B_FLAG);
    rd(adr(0, 0), v);
    chk("R6 write does not set flag", {31'd0, v[8]}, 32'd0);
    wrw(adr(0, 1), 32'd2);
    wrw(adr(0, 0), B_EN | B_DOWN | B_RLD);
    wrw(adr(0, 0), B_EN | B_DOWN | B_RLD | B_FLAG);
    rd(adr(0, 0), v);
    chk("R6 expiry beats clear", {31'd0, v[8]}, 32'd1);
    rd(adr(0, 2), v);
    chk("R8 restart on write", v, 32'd2);
    wrw(adr(0, 0), 32'd0);
    wrw(adr(0, 0), B_FLAG);
    rd(adr(0, 0), v);
    chk("R6 cleared after stop", {31'd0, v[8]}, 32'd0);

    // R7: registered interrupt, channel 0
    wrw(adr(0, 1), 32'd3);
    wrw(adr(0, 0), B_EN | B_DOWN | B_IEN);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 3) chk("R7 irq lags flag", {31'd0, irq}, 32'd0);
      if (k == 4) begin
        chk("R7 irq high", {31'd0, irq}, 32'd1);
        chk("R7 irq high single", {31'd0, irq1}, 32'd1);
      end
    end
    wrw(adr(0, 0), B_FLAG);
    chk("R7 irq holds one cycle", {31'd0, irq}, 32'd1);
    @(negedge clk);
    chk("R7 irq drops", {31'd0, irq}, 32'd0);

    // R7 / R11: channel 1 interrupt, absent in single config
    wrw(adr(1, 1), 32'd1);
    wrw(adr(1, 0), B_EN | B_DOWN | B_IEN);
    repeat (2) @(negedge clk);
    chk("R7 irq from channel 1", {31'd0, irq}, 32'd1);
    chk("R11 no irq from missing channel", {31'd0, irq1}, 32'd0);
    wrw(adr(1, 0), B_FLAG);
    @(negedge clk);

    // R8: halt holds, restart reloads
    wrw(adr(0, 1), 32'd100);
    wrw(adr(0, 0), B_EN | B_DOWN);
    wrw(adr(0, 0), B_DOWN);
    rd(adr(0, 2), v);
    chk("R8 halt value", v, 32'd99);
    repeat (3) @(negedge clk);
    rd(adr(0, 2), v);
    chk("R8 halt holds", v, 32'd99);
    wrw(adr(0, 0), B_EN | B_DOWN);
    rd(adr(0, 2), v);
    chk("R8 restart from load", v, 32'd100);
    wrw(adr(0, 0), 32'd0);

    // R9: load write isolation
    wrw(adr(0, 1), 32'd50);
    wrw(adr(0, 0), B_EN | B_DOWN);
    wrw(adr(0, 1), 32'd7);
    rd(adr(0, 2), v);
    chk("R9 running count undisturbed", v, 32'd48);
    wrw(adr(0, 0), 32'd0);
    wrw(adr(0, 1), 32'd3);
    wrw(adr(0, 0), B_EN | B_DOWN | B_RLD);
    wrw(adr(0, 1), 32'd5);
    rd(adr(0, 2), v);
    chk("R9 count before reload", v, 32'd1);
    @(negedge clk);
    rd(adr(0, 2), v);
    chk("R9 new load used at reload", v, 32'd5);
    wrw(adr(0, 0), 32'd0);
    wrw(adr(0, 0), B_FLAG);

    // R10: control register width
    wrw(adr(0, 0), 32'hFFFF_F67F);
    rd(adr(0, 0), v);
    chk("R10 control readback", v, 32'h0000_067F);
    wrw(adr(0, 0), 32'd0);

    // R11: spare word and missing channel
    wrw(adr(0, 1), 32'h1234);
    wrw(adr(0, 3), 32'hDEAD_BEEF);
    rd(adr(0, 3), v);
    chk("R11 spare word reads zero", v, 32'd0);
    rd(adr(0, 1), v);
    chk("R11 spare write ignored", v, 32'h1234);
    wrw(adr(1, 1), 32'd9);
    rd1(adr(1, 1), v1);
    chk("R11 missing channel reads zero", v1, 32'd0);
    rd(adr(1, 1), v);
    chk("R11 channel 1 load", v, 32'd9);

    // R12: independent channels
    wrw(adr(0, 1), 32'd10);
    wrw(adr(0, 0), B_EN | B_DOWN);
    wrw(adr(1, 1), 32'd4);
    wrw(adr(1, 0), B_EN | B_DOWN);
    rd(adr(0, 2), v);
    chk("R12 channel 0 count", v, 32'd6);
    rd(adr(1, 2), v);
    chk("R12 channel 1 count", v, 32'd4);
    repeat (2) @(negedge clk);
    rd(adr(0, 2), v);
    chk("R12 channel 0 later", v, 32'd4);
    rd(adr(1, 2), v);
    chk("R12 channel 1 later", v, 32'd2);
    wrw(adr(0, 0), B_FLAG);
    wrw(adr(1, 0), B_FLAG);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule